// File: doc/BRIEF.md
# Activity Monitor Counter Bank

This block keeps a per-core set of 64-bit activity counters for system-management telemetry. Four counters form a fixed architected group: core clock cycles, constant-rate ticks, retired instructions and dispatch stall cycles caused by last-level-cache misses. A second group of up to sixteen auxiliary counters, its size set by a parameter, advances on generic event strobes. Counting is gated per counter by an enable mask and frozen for the whole bank while the core sits in a wait-for-interrupt or wait-for-event low-power state.

Software reaches the counters and the two enable masks through a simple register request port. A request is accepted on every cycle it is presented; there is no back-pressure. A read returns its data with a one-cycle response strobe, and a write returns nothing. An access-trap control blocks lower-privilege requests: a blocked request changes nothing, returns no data and raises a trap flag for one cycle.

Top module: `amon_bank`

## Requirements
- R1: Counter slot 0 advances by one every clock, slot 1 by one on each cycle `tick_i` is high, slot 2 by the value on `instr_cnt_i` and slot 3 by the value on `stall_cnt_i`; the last two may add more than one in a single clock. Register addresses 0 to 3 select these slots.
- R2: Auxiliary counter j (j below `NUM_AUX`) sits at address 16+j and advances by one on each cycle `aux_evt_i[j]` is high; an address 16+j with j at or above `NUM_AUX` reads as zero.
- R3: While `wait_lp_i` is high no counter advances, whatever its event inputs carry.
- R4: After reset every counter holds zero and both enable masks are zero.
- R5: A counter whose enable bit is 0 neither advances nor loses its value, and a read of it returns zero; once enabled again it reads its kept value.
- R6: Address 8 sets the architected enable bits written as 1, address 9 clears those written as 1, addresses 10 and 11 do the same for the auxiliary mask; bit k of a mask enables slot k of its group, and a read of either address of a pair returns the current mask.
- R7: Auxiliary enable bits at or above `NUM_AUX` read as zero and ignore writes.
- R8: A counter wraps from all ones to zero, also when a multi-count increment passes the top.
- R9: A write to a counter in the same cycle as one of its events leaves the written value.
- R10: When `trap_en_i` is 1, a request with `req_lowpriv_i` high makes no change, yields no response and raises `trap_o` in the next cycle; a higher-privilege request proceeds.
- R11: A read accepted at a clock edge sets `rsp_valid_o` for the following cycle with the value the register held just before that edge; a write never sets `rsp_valid_o`.
- R12: An unmapped address reads as zero and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low cold reset |
| wait_lp_i | input | 1 | Core is in a low-power wait state |
| tick_i | input | 1 | Constant-rate tick pulse |
| instr_cnt_i | input | INC_W | Instructions retired this cycle |
| stall_cnt_i | input | INC_W | Cache-miss stall count this cycle |
| aux_evt_i | input | NUM_AUX | Auxiliary event strobes |
| trap_en_i | input | 1 | Access-trap control |
| req_valid_i | input | 1 | Register request present |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_lowpriv_i | input | 1 | Request comes from lower privilege |
| req_addr_i | input | 5 | Register address |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 64 | Read data |
| trap_o | output | 1 | Request was refused by the trap |

## Verification
Counter deltas are measured between two reads, so the cycle counter shows the exact edge count and a mixed run of awake and low-power cycles tells freezing apart from slowing. Multi-valued instruction and stall sequences tell a summing counter from one that only counts nonzero cycles, and a near-top preload shows a carry through the wrap. Preloads with a coincident event, set and clear masks with overlapping bits, and identical requests with the trap on and off separate write priority, mask semantics and privilege gating.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 5;
  localparam int ARCH_N = 4;

  localparam logic [ADDR_W-1:0] A_ARCH_SET = 5'd8;
  localparam logic [ADDR_W-1:0] A_ARCH_CLR = 5'd9;
  localparam logic [ADDR_W-1:0] A_AUX_SET  = 5'd10;
  localparam logic [ADDR_W-1:0] A_AUX_CLR  = 5'd11;
endpackage

// File: rtl/amon_counter.sv
module amon_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         frz_i,
  input  logic [W-1:0] inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (ld_i)          cnt_q <= ld_data_i;
    else if (en_i && !frz_i) cnt_q <= cnt_q + inc_i;
  end

  assign cnt_o = cnt_q;

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_i && !ld_i) |=> $stable(cnt_q));

  assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ld_i) |=> $stable(cnt_q));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(ld_data_i)));
endmodule

// File: rtl/amon_enable_reg.sv
module amon_enable_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= '0;
    else if (set_we_i) mask_q <= mask_q | wdata_i;
    else if (clr_we_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

  assert_set_only_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))
                 && ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i))));

  assert_clr_only_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/amon_port.sv
module amon_port
  import amon_pkg::*;
#(
  parameter int NUM_AUX = 4,
  localparam int NCNT   = ARCH_N + NUM_AUX
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trap_en_i,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic                       req_lowpriv_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [NCNT-1:0][CNT_W-1:0] cnt_i,
  input  logic [ARCH_N-1:0]          arch_en_i,
  input  logic [NUM_AUX-1:0]         aux_en_i,
  output logic [NCNT-1:0]            ld_o,
  output logic                       arch_set_o,
  output logic                       arch_clr_o,
  output logic                       aux_set_o,
  output logic                       aux_clr_o,
  output logic                       rsp_valid_o,
  output logic [CNT_W-1:0]           rsp_data_o,
  output logic                       trap_o
);
  localparam logic [4:0] AUX_LIM = 5'(NUM_AUX);

  logic              refused, granted, do_wr, do_rd;
  logic              hit_arch, hit_aux, hit_cnt;
  logic [4:0]        slot;
  logic [NCNT-1:0]   en_all;
  logic [CNT_W-1:0]  rd_val;
  logic              rsp_valid_q, trap_q;
  logic [CNT_W-1:0]  rsp_data_q;

  assign refused  = req_valid_i && trap_en_i && req_lowpriv_i;
  assign granted  = req_valid_i && !refused;
  assign do_wr    = granted && req_write_i;
  assign do_rd    = granted && !req_write_i;

  assign hit_arch = (req_addr_i[4:2] == 3'b000);
  assign hit_aux  = req_addr_i[4] && ({1'b0, req_addr_i[3:0]} < AUX_LIM);
  assign hit_cnt  = hit_arch || hit_aux;
  assign slot     = hit_arch ? {3'b000, req_addr_i[1:0]}
                             : ({1'b0, req_addr_i[3:0]} + 5'(ARCH_N));
  assign en_all   = {aux_en_i, arch_en_i};

  always_comb begin
    rd_val = '0;
    if (hit_cnt) begin
      for (int s = 0; s < NCNT; s++) begin
        if (slot == 5'(s) && en_all[s]) rd_val = cnt_i[s];
      end
    end else begin
      case (req_addr_i)
        A_ARCH_SET, A_ARCH_CLR: rd_val = CNT_W'(arch_en_i);
        A_AUX_SET,  A_AUX_CLR:  rd_val = CNT_W'(aux_en_i);
        default:                rd_val = '0;
      endcase
    end
  end

  generate
    for (genvar s = 0; s < NCNT; s++) begin : g_ld
      assign ld_o[s] = do_wr && hit_cnt && (slot == 5'(s));
    end
  endgenerate

  assign arch_set_o = do_wr && (req_addr_i == A_ARCH_SET);
  assign arch_clr_o = do_wr && (req_addr_i == A_ARCH_CLR);
  assign aux_set_o  = do_wr && (req_addr_i == A_AUX_SET);
  assign aux_clr_o  = do_wr && (req_addr_i == A_AUX_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      trap_q      <= 1'b0;
    end else begin
      rsp_valid_q <= do_rd;
      rsp_data_q  <= do_rd ? rd_val : '0;
      trap_q      <= refused;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign trap_o      = trap_q;

  assert_trap_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (trap_o && !rsp_valid_o));

  assert_no_write_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);

  assert_disabled_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && hit_cnt && ((en_all & (NCNT'(1) << slot)) == '0)) |=> (rsp_data_o == '0));

  assert_refused_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> (ld_o == '0) && !arch_set_o && !arch_clr_o && !aux_set_o && !aux_clr_o);
endmodule

// File: rtl/amon_bank.sv
module amon_bank
  import amon_pkg::*;
#(
  parameter int NUM_AUX = 4,
  parameter int INC_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wait_lp_i,
  input  logic                tick_i,
  input  logic [INC_W-1:0]    instr_cnt_i,
  input  logic [INC_W-1:0]    stall_cnt_i,
  input  logic [NUM_AUX-1:0]  aux_evt_i,
  input  logic                trap_en_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic                req_lowpriv_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [CNT_W-1:0]    req_wdata_i,
  output logic                rsp_valid_o,
  output logic [CNT_W-1:0]    rsp_data_o,
  output logic                trap_o
);
  localparam int NCNT = ARCH_N + NUM_AUX;

  logic [NCNT-1:0][CNT_W-1:0] cnt_v;
  logic [NCNT-1:0][CNT_W-1:0] inc_v;
  logic [NCNT-1:0]            ld_v;
  logic [NCNT-1:0]            en_v;
  logic [ARCH_N-1:0]          arch_en;
  logic [NUM_AUX-1:0]         aux_en;
  logic arch_set, arch_clr, aux_set, aux_clr;

  assign inc_v[0] = CNT_W'(1);
  assign inc_v[1] = CNT_W'(tick_i);
  assign inc_v[2] = CNT_W'(instr_cnt_i);
  assign inc_v[3] = CNT_W'(stall_cnt_i);
  assign en_v     = {aux_en, arch_en};

  generate
    for (genvar j = 0; j < NUM_AUX; j++) begin : g_aux_inc
      assign inc_v[ARCH_N+j] = CNT_W'(aux_evt_i[j]);
    end
    for (genvar s = 0; s < NCNT; s++) begin : g_cnt
      amon_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_v[s]),
        .frz_i     (wait_lp_i),
        .inc_i     (inc_v[s]),
        .ld_i      (ld_v[s]),
        .ld_data_i (req_wdata_i),
        .cnt_o     (cnt_v[s])
      );
    end
  endgenerate

  amon_enable_reg #(.N(ARCH_N)) u_arch_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we_i (arch_set),
    .clr_we_i (arch_clr),
    .wdata_i  (req_wdata_i[ARCH_N-1:0]),
    .mask_o   (arch_en)
  );

  amon_enable_reg #(.N(NUM_AUX)) u_aux_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we_i (aux_set),
    .clr_we_i (aux_clr),
    .wdata_i  (req_wdata_i[NUM_AUX-1:0]),
    .mask_o   (aux_en)
  );

  amon_port #(.NUM_AUX(NUM_AUX)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_en_i     (trap_en_i),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_lowpriv_i (req_lowpriv_i),
    .req_addr_i    (req_addr_i),
    .cnt_i         (cnt_v),
    .arch_en_i     (arch_en),
    .aux_en_i      (aux_en),
    .ld_o          (ld_v),
    .arch_set_o    (arch_set),
    .arch_clr_o    (arch_clr),
    .aux_set_o     (aux_set),
    .aux_clr_o     (aux_clr),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o),
    .trap_o        (trap_o)
  );

  assert_reset_clear_R4: assert property (@(posedge clk)
    !rst_n |=> (arch_en == '0) && (aux_en == '0) && (cnt_v[0] == '0));

  assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_en[0] && !wait_lp_i && !ld_v[0]) |=> (cnt_v[0] == $past(cnt_v[0]) + CNT_W'(1)));
endmodule

// File: tb/test_amon_bank.sv
`timescale 1ns/1ps
module test_amon_bank;
  localparam int NUM_AUX = 4;
  localparam int INC_W   = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wait_lp, tick;
  logic [INC_W-1:0]   instr_cnt, stall_cnt;
  logic [NUM_AUX-1:0] aux_evt;
  logic               trap_en, req_valid, req_write, req_lowpriv;
  logic [4:0]         req_addr;
  logic [63:0]        req_wdata;
  logic               rsp_valid, trap_flag;
  logic [63:0]        rsp_data;

  int total = 0;
  int bad   = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  amon_bank #(.NUM_AUX(NUM_AUX), .INC_W(INC_W)) i_amon_bank (
    .clk(clk), .rst_n(rst_n), .wait_lp_i(wait_lp), .tick_i(tick),
    .instr_cnt_i(instr_cnt), .stall_cnt_i(stall_cnt), .aux_evt_i(aux_evt),
    .trap_en_i(trap_en), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_lowpriv_i(req_lowpriv), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .trap_o(trap_flag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d, input bit lp);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_lowpriv = lp;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input bit lp,
                    output logic [63:0] d, output logic v, output logic t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_lowpriv = lp;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data; v = rsp_valid; t = trap_flag;
  endtask

  logic [63:0] a0, b0, c0, d0;
  logic        v, t;

  task automatic t_reset;
    rd(5'd8, 0, a0, v, t);  chk("R4 arch mask after reset", a0, 0);
    rd(5'd10, 0, a0, v, t); chk("R4 aux mask after reset", a0, 0);
    wr(5'd8, 64'h2, 0);
    wr(5'd10, 64'hF, 0);
    rd(5'd1, 0, a0, v, t);  chk("R4 constant counter zero", a0, 0);
    for (int j = 0; j < NUM_AUX; j++) begin
      rd(5'(16 + j), 0, a0, v, t); chk("R4 aux counter zero", a0, 0);
    end
    wr(5'd9, 64'hF, 0);
    wr(5'd11, 64'hF, 0);
  endtask

  task automatic t_enable;
    wr(5'd8, 64'h5, 0);
    chk("R11 write gives no response", {63'd0, rsp_valid}, 0);
    rd(5'd8, 0, a0, v, t);  chk("R6 set 0101", a0, 64'h5);
    wr(5'd8, 64'h2, 0);
    rd(5'd8, 0, a0, v, t);  chk("R6 set adds bit", a0, 64'h7);
    wr(5'd9, 64'h4, 0);
    rd(5'd9, 0, a0, v, t);  chk("R6 clear removes bit", a0, 64'h3);
    wr(5'd10, 64'hFFFF, 0);
    rd(5'd10, 0, a0, v, t); chk("R7 absent aux bits zero", a0, 64'hF);
    wr(5'd11, 64'hFFF2, 0);
    rd(5'd11, 0, a0, v, t); chk("R6 aux clear", a0, 64'hD);
    wr(5'd9, 64'hF, 0);
    wr(5'd11, 64'hF, 0);
  endtask

  task automatic t_cycles;
    wr(5'd8, 64'h1, 0);
    rd(5'd0, 0, a0, v, t);
    chk("R11 read response valid", {63'd0, v}, 1);
    rd(5'd0, 0, b0, v, t);  chk("R11 back-to-back delta", b0 - a0, 1);
    idle(4);
    rd(5'd0, 0, c0, v, t);  chk("R1 cycle counter delta", c0 - b0, 5);
  endtask

  task automatic t_wait;
    rd(5'd0, 0, a0, v, t);
    idle(3); wait_lp = 1'b1; idle(5); wait_lp = 1'b0; idle(2);
    rd(5'd0, 0, b0, v, t);  chk("R3 cycle frozen in wait", b0 - a0, 6);
    wr(5'd8, 64'h4, 0);
    rd(5'd2, 0, a0, v, t);
    wait_lp = 1'b1; instr_cnt = 3'd5; idle(4); instr_cnt = 3'd0; wait_lp = 1'b0;
    rd(5'd2, 0, b0, v, t);  chk("R3 instr frozen in wait", b0 - a0, 0);
  endtask

  task automatic t_arch_events;
    wr(5'd8, 64'hE, 0);
    rd(5'd1, 0, a0, v, t);
    for (int k = 0; k < 7; k++) begin
      tick = 1'b1; idle(1); tick = 1'b0; idle(k % 2);
    end
    rd(5'd1, 0, b0, v, t);  chk("R1 constant tick count", b0 - a0, 7);
    rd(5'd2, 0, a0, v, t);
    rd(5'd3, 0, c0, v, t);
    instr_cnt = 3'd3; stall_cnt = 3'd2; idle(1);
    instr_cnt = 3'd7; stall_cnt = 3'd0; idle(1);
    instr_cnt = 3'd0; stall_cnt = 3'd5; idle(1);
    instr_cnt = 3'd1; stall_cnt = 3'd0; idle(1);
    instr_cnt = 3'd0;
    rd(5'd2, 0, b0, v, t);  chk("R1 instr multi-count sum", b0 - a0, 11);
    rd(5'd3, 0, d0, v, t);  chk("R1 stall multi-count sum", d0 - c0, 7);
  endtask

  task automatic t_disabled;
    wr(5'd9, 64'h2, 0);
    wr(5'd1, 64'd123, 0);
    rd(5'd1, 0, a0, v, t);  chk("R5 disabled reads zero", a0, 0);
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1; idle(1); tick = 1'b0; idle(1);
    end
    wr(5'd8, 64'h2, 0);
    rd(5'd1, 0, a0, v, t);  chk("R5 value kept while disabled", a0, 64'd123);
  endtask

  task automatic t_aux;
    wr(5'd10, 64'hF, 0);
    rd(5'd18, 0, a0, v, t);
    for (int k = 0; k < 4; k++) begin
      aux_evt = (k < 2) ? 4'b0101 : 4'b0100; idle(1); aux_evt = '0; idle(1);
    end
    rd(5'd18, 0, b0, v, t); chk("R2 aux2 strobe count", b0 - a0, 4);
    rd(5'd21, 0, a0, v, t);
    chk("R2 absent aux counter zero", a0, 0);
    chk("R2 absent aux read responds", {63'd0, v}, 1);
  endtask

  task automatic t_wrap;
    wr(5'd17, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    aux_evt = 4'b0010; idle(1); aux_evt = '0;
    rd(5'd17, 0, a0, v, t); chk("R8 aux wraps to zero", a0, 0);
    wr(5'd2, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    instr_cnt = 3'd5; idle(1); instr_cnt = 3'd0;
    rd(5'd2, 0, a0, v, t);  chk("R8 multi-count wrap", a0, 64'd3);
  endtask

  task automatic t_write_wins;
    aux_evt = 4'b0001;
    wr(5'd16, 64'd5, 0);
    aux_evt = '0;
    rd(5'd16, 0, a0, v, t); chk("R9 write beats event", a0, 64'd5);
  endtask

  task automatic t_trap;
    trap_en = 1'b1;
    wr(5'd19, 64'd99, 1);
    chk("R10 trapped write flags", {63'd0, trap_flag}, 1);
    rd(5'd19, 1, a0, v, t);
    chk("R10 trapped read no response", {63'd0, v}, 0);
    chk("R10 trapped read flags", {63'd0, t}, 1);
    rd(5'd19, 0, a0, v, t);
    chk("R10 privileged read allowed", {62'd0, v, t}, 64'h2);
    chk("R10 trapped write had no effect", a0, 0);
    wr(5'd9, 64'hF, 1);
    rd(5'd8, 0, a0, v, t);  chk("R10 trapped clear ignored", a0, 64'hF);
    trap_en = 1'b0;
    rd(5'd16, 1, a0, v, t);
    chk("R10 low privilege ok with trap off", {63'd0, v}, 1);
  endtask

  task automatic t_unmapped;
    rd(5'd6, 0, a0, v, t);  chk("R12 unmapped reads zero", a0, 0);
    wr(5'd13, 64'hFFFF, 0);
    wr(5'd4, 64'hFFFF, 0);
    rd(5'd8, 0, a0, v, t);  chk("R12 arch mask untouched", a0, 64'hF);
    rd(5'd10, 0, a0, v, t); chk("R12 aux mask untouched", a0, 64'hF);
  endtask

  initial begin
    rst_n = 1'b0; wait_lp = 1'b0; tick = 1'b0; instr_cnt = '0; stall_cnt = '0;
    aux_evt = '0; trap_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_lowpriv = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset; t_enable; t_cycles; t_wait; t_arch_events;
        t_disabled; t_aux; t_wrap; t_write_wins; t_trap; t_unmapped;
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule